// File: doc/BRIEF.md
# Digit-Recurrence Divide / Square-Root / Reciprocal-Square-Root Pipeline

This block is the iterative heart of a shared fixed-point engine. It handles three operations: unsigned division with remainder, square root with remainder, and reciprocal square root with remainder. A record flows through a chain of registered stages. The record holds:

- the operand (divisor or radicand),
- a two-bit operation code,
- the partial root or quotient,
- the running product of that root and the operand,
- a comparison target,
- the current trial value that is compared against the target.

Each stage owns a group of result bits, starting at the most significant end. It evaluates every digit value for its group in parallel. It keeps the largest digit whose trial value stays at or below the target.

The target arrives prescaled by the surrounding logic, which is outside this block:

- Division: the dividend shifted left by `FW`.
- Square root: the radicand shifted left by `2*FW`.
- Reciprocal square root: one shifted left by `3*FW`.

The first stage is fed with a zero root, a zero product and a zero trial value. The remainder is the target minus the final trial value. Widths are parameters: `BW` is the operand and root width, `FW` the number of fractional bits, and `RADIX_BITS` the number of result bits retired per stage.

Top module: `rootdiv_recur`

## Requirements
- R1: `in_op` selects the operation: 0 divides, 1 takes the square root, and 2 or 3 takes the reciprocal square root. For division, `out_root` is the largest `BW`-bit q with q·opnd·2^FW ≤ target.
- R2: Division by a zero operand yields an all-ones `out_root`, a zero `out_rprod` and a zero `out_trial`.
- R3: For square root, `out_root` is the largest `BW`-bit q with q²·2^FW ≤ target, and `out_trial` equals q²·2^FW.
- R4: For reciprocal square root, `out_root` is the largest `BW`-bit q with q²·opnd ≤ target, and `out_trial` equals q²·opnd. A zero operand yields all ones.
- R5: `out_rprod` equals `out_root` × `out_opnd`. For division, `out_trial` equals `out_rprod`·2^FW.
- R6: `out_op`, `out_opnd` and `out_target` equal the values presented with the same record.
- R7: A record presented with `in_valid` high emerges with `out_valid` high exactly ceil(BW/RADIX_BITS) cycles later, in order. No output is valid without a matching input. Reset clears every valid flag.
- R8: `out_trial` never exceeds `out_target`, so the remainder is non-negative.
- R9: Stages decide result bits from the most significant end, and each stage leaves bits outside its own group unchanged. When `BW` is not a multiple of `RADIX_BITS`, the last stage decides the remaining narrower group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid flags |
| in_valid | input | 1 | Record present at the input |
| in_op | input | 2 | Operation code (0 divide, 1 sqrt, 2/3 rsqrt) |
| in_opnd | input | BW | Divisor or radicand |
| in_root | input | BW | Partial quotient/root on entry (zero for a fresh record) |
| in_rprod | input | 2*BW | Root × operand on entry |
| in_target | input | 3*BW | Prescaled comparison target |
| in_trial | input | 3*BW | Trial value of the entry root |
| out_valid | output | 1 | Record present at the output |
| out_op | output | 2 | Operation code carried through |
| out_opnd | output | BW | Operand carried through |
| out_root | output | BW | Final quotient or root |
| out_rprod | output | 2*BW | Final root × operand |
| out_target | output | 3*BW | Target carried through |
| out_trial | output | 3*BW | Trial value of the final root; remainder = target − trial |

## Verification
The stage assertions take the entry record to be self-consistent. That means the product equals root × operand, the trial value belongs to that root and does not exceed the target, and the root bits of every group not yet decided are zero. They also take `in_valid` to be low while reset is held.

The bench keeps within these conditions by always presenting fresh records with zero root, product and trial. It prescales the target exactly as the three operations define, and it holds `in_valid` low until reset is released.

Two small configurations are swept almost exhaustively. One has a width that divides evenly into groups and one does not. Every operand pair is covered for division, and every operand is covered for both root operations. Zero operands and all-ones inputs are included, and idle gaps are inserted in the stream.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

   typedef enum logic [1:0] {
      RDR_DIV       = 2'd0,
      RDR_SQRT      = 2'd1,
      RDR_RSQRT     = 2'd2,
      RDR_RSQRT_ALT = 2'd3
   } rdr_op_e;

   // number of stages needed to settle bw result bits, rb bits per stage
   function automatic int rdr_stage_count(input int bw, input int rb);
      return (bw + rb - 1) / rb;
   endfunction

   // exclusive upper bit index of the group settled by stage s
   function automatic int rdr_group_top(input int bw, input int rb, input int s);
      return bw - s * rb;
   endfunction

   // width of the group settled by stage s (last one may be narrower)
   function automatic int rdr_group_width(input int bw, input int rb, input int s);
      int top;
      top = bw - s * rb;
      return (top < rb) ? top : rb;
   endfunction

endpackage

// File: rtl/rdr_candidate.sv
// One nonzero trial digit: forms the trial root, product and trial value
// and reports whether the trial value still fits under the target.
module rdr_candidate
   import rdr_pkg::*;
#(
   parameter int BW    = 8,
   parameter int FW    = 4,
   parameter int POS   = 0,
   parameter int DW    = 2,
   parameter int DIGIT = 1
) (
   input  logic [1:0]        op,
   input  logic [BW-1:0]     opnd,
   input  logic [BW-1:0]     root,
   input  logic [2*BW-1:0]   rprod,
   input  logic [3*BW-1:0]   target,
   output logic [BW-1:0]     t_root,
   output logic [2*BW-1:0]   t_rprod,
   output logic [3*BW-1:0]   t_trial,
   output logic              fits
);
   localparam int PW = 2 * BW;
   localparam int TW = 3 * BW;
   localparam logic [BW-1:0] FIELD = BW'((1 << DW) - 1) << POS;
   localparam logic [BW-1:0] DVAL  = BW'(DIGIT) << POS;

   if (DIGIT < 1 || DIGIT >= (1 << DW)) begin : g_bad_digit
      $error("rdr_candidate: DIGIT out of range for its group");
   end
   if (POS + DW > BW) begin : g_bad_pos
      $error("rdr_candidate: group exceeds root width");
   end

   logic [PW-1:0] step;
   logic [PW-1:0] square;

   assign t_root  = (root & ~FIELD) | DVAL;
   assign step    = (PW'(opnd) * PW'(DIGIT)) << POS;
   assign t_rprod = rprod + step;
   assign square  = PW'(t_root) * PW'(t_root);

   always_comb begin
      case (rdr_op_e'(op))
         RDR_DIV:  t_trial = TW'(t_rprod) << FW;
         RDR_SQRT: t_trial = TW'(square) << FW;
         default:  t_trial = TW'(t_root) * TW'(t_rprod);
      endcase
   end

   assign fits = (t_trial <= target);

endmodule

// File: rtl/rdr_stage.sv
// One registered recurrence stage: settles the result group for STAGE.
module rdr_stage
   import rdr_pkg::*;
#(
   parameter int BW    = 8,
   parameter int FW    = 4,
   parameter int RB    = 2,
   parameter int STAGE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   input  logic [1:0]        i_op,
   input  logic [BW-1:0]     i_opnd,
   input  logic [BW-1:0]     i_root,
   input  logic [2*BW-1:0]   i_rprod,
   input  logic [3*BW-1:0]   i_target,
   input  logic [3*BW-1:0]   i_trial,
   output logic              o_valid,
   output logic [1:0]        o_op,
   output logic [BW-1:0]     o_opnd,
   output logic [BW-1:0]     o_root,
   output logic [2*BW-1:0]   o_rprod,
   output logic [3*BW-1:0]   o_target,
   output logic [3*BW-1:0]   o_trial
);
   localparam int PW  = 2 * BW;
   localparam int TW  = 3 * BW;
   localparam int TOP = rdr_group_top(BW, RB, STAGE);
   localparam int DW  = rdr_group_width(BW, RB, STAGE);
   localparam int POS = TOP - DW;
   localparam int NC  = 1 << DW;
   localparam logic [BW-1:0] FIELD = BW'((1 << DW) - 1) << POS;

   if (TOP < 1) begin : g_bad_stage
      $error("rdr_stage: STAGE beyond the last result group");
   end
   if (RB < 1) begin : g_bad_radix
      $error("rdr_stage: RB must be at least one");
   end

   logic [BW-1:0] c_root  [NC];
   logic [PW-1:0] c_rprod [NC];
   logic [TW-1:0] c_trial [NC];
   logic [NC-1:0] c_fit;
   logic [DW-1:0] sel;

   // digit zero: entry record with this group cleared, always acceptable
   assign c_root[0]  = i_root & ~FIELD;
   assign c_rprod[0] = i_rprod;
   assign c_trial[0] = i_trial;
   assign c_fit[0]   = 1'b1;

   for (genvar c = 1; c < NC; c++) begin : g_cand
      rdr_candidate #(
         .BW(BW), .FW(FW), .POS(POS), .DW(DW), .DIGIT(c)
      ) i_cand (
         .op      (i_op),
         .opnd    (i_opnd),
         .root    (i_root),
         .rprod   (i_rprod),
         .target  (i_target),
         .t_root  (c_root[c]),
         .t_rprod (c_rprod[c]),
         .t_trial (c_trial[c]),
         .fits    (c_fit[c])
      );
   end

   // largest fitting digit wins
   always_comb begin
      sel = '0;
      for (int c = 0; c < NC; c++) begin
         if (c_fit[c]) sel = DW'(c);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) o_valid <= 1'b0;
      else        o_valid <= i_valid;
   end

   always_ff @(posedge clk) begin
      o_op     <= i_op;
      o_opnd   <= i_opnd;
      o_target <= i_target;
      o_root   <= c_root[sel];
      o_rprod  <= c_rprod[sel];
      o_trial  <= c_trial[sel];
   end

   assert_valid_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> $past(i_valid));

   assert_carry_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (o_target == $past(i_target) && o_opnd == $past(i_opnd)
                   && o_op == $past(i_op)));

   assert_no_overshoot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (o_trial <= o_target));

   assert_product_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (o_rprod == PW'(o_root) * PW'(o_opnd)));

   assert_other_groups_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> ((o_root & ~FIELD) == ($past(i_root) & ~FIELD)));

endmodule

// File: rtl/rootdiv_recur.sv
module rootdiv_recur
   import rdr_pkg::*;
#(
   parameter int BW         = 8,
   parameter int FW         = 4,
   parameter int RADIX_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [BW-1:0]     in_opnd,
   input  logic [BW-1:0]     in_root,
   input  logic [2*BW-1:0]   in_rprod,
   input  logic [3*BW-1:0]   in_target,
   input  logic [3*BW-1:0]   in_trial,
   output logic              out_valid,
   output logic [1:0]        out_op,
   output logic [BW-1:0]     out_opnd,
   output logic [BW-1:0]     out_root,
   output logic [2*BW-1:0]   out_rprod,
   output logic [3*BW-1:0]   out_target,
   output logic [3*BW-1:0]   out_trial
);
   localparam int NS = rdr_stage_count(BW, RADIX_BITS);
   localparam int PW = 2 * BW;
   localparam int TW = 3 * BW;

   if (BW < 1 || FW < 0 || FW > BW) begin : g_bad_width
      $error("rootdiv_recur: need 1 <= BW and 0 <= FW <= BW");
   end
   if (RADIX_BITS < 1 || RADIX_BITS > 8) begin : g_bad_radix
      $error("rootdiv_recur: RADIX_BITS must lie in 1..8");
   end

   logic          p_valid  [NS+1];
   logic [1:0]    p_op     [NS+1];
   logic [BW-1:0] p_opnd   [NS+1];
   logic [BW-1:0] p_root   [NS+1];
   logic [PW-1:0] p_rprod  [NS+1];
   logic [TW-1:0] p_target [NS+1];
   logic [TW-1:0] p_trial  [NS+1];

   assign p_valid[0]  = in_valid;
   assign p_op[0]     = in_op;
   assign p_opnd[0]   = in_opnd;
   assign p_root[0]   = in_root;
   assign p_rprod[0]  = in_rprod;
   assign p_target[0] = in_target;
   assign p_trial[0]  = in_trial;

   for (genvar s = 0; s < NS; s++) begin : g_stage
      rdr_stage #(
         .BW(BW), .FW(FW), .RB(RADIX_BITS), .STAGE(s)
      ) i_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .i_valid  (p_valid[s]),
         .i_op     (p_op[s]),
         .i_opnd   (p_opnd[s]),
         .i_root   (p_root[s]),
         .i_rprod  (p_rprod[s]),
         .i_target (p_target[s]),
         .i_trial  (p_trial[s]),
         .o_valid  (p_valid[s+1]),
         .o_op     (p_op[s+1]),
         .o_opnd   (p_opnd[s+1]),
         .o_root   (p_root[s+1]),
         .o_rprod  (p_rprod[s+1]),
         .o_target (p_target[s+1]),
         .o_trial  (p_trial[s+1])
      );
   end

   assign out_valid  = p_valid[NS];
   assign out_op     = p_op[NS];
   assign out_opnd   = p_opnd[NS];
   assign out_root   = p_root[NS];
   assign out_rprod  = p_rprod[NS];
   assign out_target = p_target[NS];
   assign out_trial  = p_trial[NS];

endmodule

// File: tb/test_rootdiv_recur.sv
`timescale 1ns/1ps
module test_rootdiv_recur;
   localparam int A_BW = 6, A_FW = 3;
   localparam int B_BW = 5, B_FW = 2;
   localparam int RB = 2;
   localparam int NS = 3;   // ceil(6/2) and ceil(5/2)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              a_in_valid, a_out_valid;
   logic [1:0]        a_in_op, a_out_op;
   logic [A_BW-1:0]   a_in_opnd, a_in_root, a_out_opnd, a_out_root;
   logic [2*A_BW-1:0] a_in_rprod, a_out_rprod;
   logic [3*A_BW-1:0] a_in_target, a_in_trial, a_out_target, a_out_trial;

   logic              b_in_valid, b_out_valid;
   logic [1:0]        b_in_op, b_out_op;
   logic [B_BW-1:0]   b_in_opnd, b_in_root, b_out_opnd, b_out_root;
   logic [2*B_BW-1:0] b_in_rprod, b_out_rprod;
   logic [3*B_BW-1:0] b_in_target, b_in_trial, b_out_target, b_out_trial;

   rootdiv_recur #(.BW(A_BW), .FW(A_FW), .RADIX_BITS(RB)) i_rootdiv_recur (
      .clk(clk), .rst_n(rst_n), .in_valid(a_in_valid), .in_op(a_in_op),
      .in_opnd(a_in_opnd), .in_root(a_in_root), .in_rprod(a_in_rprod),
      .in_target(a_in_target), .in_trial(a_in_trial),
      .out_valid(a_out_valid), .out_op(a_out_op), .out_opnd(a_out_opnd),
      .out_root(a_out_root), .out_rprod(a_out_rprod),
      .out_target(a_out_target), .out_trial(a_out_trial));

   rootdiv_recur #(.BW(B_BW), .FW(B_FW), .RADIX_BITS(RB)) i_rootdiv_recur_ragged (
      .clk(clk), .rst_n(rst_n), .in_valid(b_in_valid), .in_op(b_in_op),
      .in_opnd(b_in_opnd), .in_root(b_in_root), .in_rprod(b_in_rprod),
      .in_target(b_in_target), .in_trial(b_in_trial),
      .out_valid(b_out_valid), .out_op(b_out_op), .out_opnd(b_out_opnd),
      .out_root(b_out_root), .out_rprod(b_out_rprod),
      .out_target(b_out_target), .out_trial(b_out_trial));

   int n_chk = 0, n_fail = 0, cyc = 0, n_issue = 0;
   int     a_op_q [16], b_op_q [16], a_cyc_q [16], b_cyc_q [16];
   longint a_opnd_q [16], b_opnd_q [16], a_tgt_q [16], b_tgt_q [16];
   int a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;

   task automatic note(input bit good, input string req, input string what,
                       input longint act, input longint exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint trial_of(input int op, input longint q,
                                       input longint d, input int fw);
      if (op == 0) return (q * d) << fw;
      if (op == 1) return (q * q) << fw;
      return q * q * d;
   endfunction

   function automatic longint best_root(input int op, input longint d,
                                        input longint tgt, input int bw, input int fw);
      for (longint q = (longint'(1) << bw) - 1; q > 0; q--)
         if (trial_of(op, q, d, fw) <= tgt) return q;
      return 0;
   endfunction

   task automatic judge(input string cfg, input bit ragged, input int bw, input int fw,
                        input int op, input longint d, input longint tgt, input int icyc,
                        input int oop, input longint od, input longint oq,
                        input longint oprod, input longint otgt, input longint otrial);
      longint q_exp;
      string rq;
      q_exp = best_root(op, d, tgt, bw, fw);
      if (op == 0) rq = (d == 0) ? "R2" : "R1";
      else if (op == 1) rq = "R3";
      else rq = "R4";
      if (ragged) rq = {rq, "+R9"};
      note(oq == q_exp, rq, {cfg, " root"}, oq, q_exp);
      note(otrial == trial_of(op, q_exp, d, fw), rq, {cfg, " trial"}, otrial,
           trial_of(op, q_exp, d, fw));
      note(oprod == q_exp * d, "R5", {cfg, " product"}, oprod, q_exp * d);
      note(otgt == tgt, "R6", {cfg, " target"}, otgt, tgt);
      note(od == d && oop == op, "R6", {cfg, " operand/op"}, od, d);
      note(cyc - icyc == NS, "R7", {cfg, " latency"}, cyc - icyc, NS);
      note(otrial <= otgt, "R8", {cfg, " remainder sign"}, otrial, otgt);
   endtask

   task automatic service();
      cyc++;
      if (a_out_valid) begin
         if (a_rd == a_wr) note(1'b0, "R7", "A output without input", 1, 0);
         else begin
            judge("A", 1'b0, A_BW, A_FW, a_op_q[a_rd%16], a_opnd_q[a_rd%16],
                  a_tgt_q[a_rd%16], a_cyc_q[a_rd%16], int'(a_out_op),
                  longint'(a_out_opnd), longint'(a_out_root), longint'(a_out_rprod),
                  longint'(a_out_target), longint'(a_out_trial));
            a_rd++;
         end
      end
      if (b_out_valid) begin
         if (b_rd == b_wr) note(1'b0, "R7", "B output without input", 1, 0);
         else begin
            judge("B", 1'b1, B_BW, B_FW, b_op_q[b_rd%16], b_opnd_q[b_rd%16],
                  b_tgt_q[b_rd%16], b_cyc_q[b_rd%16], int'(b_out_op),
                  longint'(b_out_opnd), longint'(b_out_root), longint'(b_out_rprod),
                  longint'(b_out_target), longint'(b_out_trial));
            b_rd++;
         end
      end
   endtask

   task automatic idle();
      @(negedge clk);
      service();
      a_in_valid = 1'b0;
      b_in_valid = 1'b0;
   endtask

   task automatic issue(input bit to_b, input int op, input longint d, input longint tgt);
      if (n_issue % 11 == 10) idle();
      n_issue++;
      @(negedge clk);
      service();
      a_in_valid = 1'b0;
      b_in_valid = 1'b0;
      if (!to_b) begin
         a_in_valid = 1'b1; a_in_op = 2'(op); a_in_opnd = A_BW'(d);
         a_in_target = (3*A_BW)'(tgt);
         a_op_q[a_wr%16] = op; a_opnd_q[a_wr%16] = d;
         a_tgt_q[a_wr%16] = tgt; a_cyc_q[a_wr%16] = cyc;
         a_wr++;
      end else begin
         b_in_valid = 1'b1; b_in_op = 2'(op); b_in_opnd = B_BW'(d);
         b_in_target = (3*B_BW)'(tgt);
         b_op_q[b_wr%16] = op; b_opnd_q[b_wr%16] = d;
         b_tgt_q[b_wr%16] = tgt; b_cyc_q[b_wr%16] = cyc;
         b_wr++;
      end
   endtask

   initial begin
      a_in_valid = 0; a_in_op = 0; a_in_opnd = 0; a_in_root = 0;
      a_in_rprod = 0; a_in_target = 0; a_in_trial = 0;
      b_in_valid = 0; b_in_op = 0; b_in_opnd = 0; b_in_root = 0;
      b_in_rprod = 0; b_in_target = 0; b_in_trial = 0;
      repeat (3) @(negedge clk);
      note(!a_out_valid && !b_out_valid, "R7", "valid during reset",
           longint'(a_out_valid) + longint'(b_out_valid), 0);
      rst_n = 1'b1;
      repeat (4) idle();
      // configuration A: every dividend/divisor pair, every radicand
      for (int n = 0; n < (1 << (A_BW + A_FW)); n++)
         for (int d = 0; d < (1 << A_BW); d++)
            issue(1'b0, 0, d, longint'(n) << A_FW);
      for (int r = 0; r < (1 << A_BW); r++) issue(1'b0, 1, r, longint'(r) << (2*A_FW));
      for (int r = 0; r < (1 << A_BW); r++) issue(1'b0, 2, r, longint'(1) << (3*A_FW));
      for (int r = 0; r < (1 << A_BW); r++) issue(1'b0, 3, r, longint'(1) << (3*A_FW));
      // configuration B: width not a multiple of the group size
      for (int n = 0; n < (1 << (B_BW + B_FW)); n++)
         for (int d = 0; d < (1 << B_BW); d++)
            issue(1'b1, 0, d, longint'(n) << B_FW);
      for (int r = 0; r < (1 << B_BW); r++) issue(1'b1, 1, r, longint'(r) << (2*B_FW));
      for (int r = 0; r < (1 << B_BW); r++) issue(1'b1, 2, r, longint'(1) << (3*B_FW));
      repeat (NS + 3) idle();
      note(a_rd == a_wr && b_rd == b_wr, "R7", "records lost",
           longint'(a_rd + b_rd), longint'(a_wr + b_wr));
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      note(1'b0, "R7", "watchdog expired", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule